// File: doc/BRIEF.md
# Twin-Clock Dual-Port Static RAM with Per-Port Read Latency

This block is a dual-port synchronous RAM of 4096 words by 18 bits. It has a left and a right port. Each port has its own clock, and each can read or write any word in the same cycle as the other. Every port samples its address, write data and controls on the rising edge of its own clock. The read/write select decides whether that edge stores data or fetches it. The word is split into two 9-bit lanes. Each lane has its own active-low select, which gates both the write into that lane and the driving of read data on it. An active-low output enable also gates the read drive.

A port is selected only when its active-low enable is low and its active-high enable is high. Each port has a mode input that picks its read latency while the block runs. In flow-through mode the fetched word appears right after the capturing edge. In pipelined mode the word passes through one more register and appears one edge later. The data pins are modelled as separate write data, read data and a per-lane read-valid pair. A lane that is not valid reads as zero.

When one port writes a word on the same edge as the other port reads it, the reader gets the old contents. The new contents are visible from its next edge onward. If both ports write the same word on the same edge, the stored value is undefined.

Top module: `twin_port_ram`

## Requirements
- R1: The array holds 4096 words of 18 bits, addressed 0x000 to 0xFFF. A word written through either port reads back unchanged through either port.
- R2: A port is selected on an edge only when its enable-0 input is 0 and its enable-1 input is 1. Any other pairing gives no write and no valid read data from that edge.
- R3: On a selected edge, read/write 0 writes and read/write 1 reads. A read edge leaves the array unchanged, whatever its write data, and a write edge makes no lane valid.
- R4: Lane select lo_n (active low) covers bits 8..0 and lane select hi_n (active low) covers bits 17..9. On a write, only the bits of lanes whose select is 0 change.
- R5: Valid bit 0 goes with bits 8..0 and valid bit 1 with bits 17..9. A lane is valid for a read only if output-enable was 0 and that lane's select was 0 on the read edge. Data bits of a lane that is not valid are 0.
- R6: With mode 0 (flow-through), the word read on edge k is on the read data, with its valid bits, from just after edge k until edge k+1.
- R7: With mode 1 (pipelined), the word read on edge k is on the read data, with its valid bits, from just after edge k+1 until edge k+2. Back-to-back reads stream one word per cycle.
- R8: In pipelined mode, a deselected edge k leaves both valid bits 0 after edge k+1. A selected read at edge k+1 drives data only after edge k+2.
- R9: When one port writes a word on the same edge as the other port reads it, the read returns the previous contents. A read of that word on a later edge returns the new contents.
- R10: While reset is low, both ports' valid bits and read data are 0. Asserting reset clears them at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| l_clk | input | 1 | Left port clock |
| l_ce0_n | input | 1 | Left enable, active low |
| l_ce1 | input | 1 | Left enable, active high |
| l_wr_n | input | 1 | Left read/write: 0 write, 1 read |
| l_lo_n | input | 1 | Left select for bits 8..0, active low |
| l_hi_n | input | 1 | Left select for bits 17..9, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_pipe | input | 1 | Left mode: 0 flow-through, 1 pipelined |
| l_addr | input | 12 | Left word address |
| l_wdata | input | 18 | Left write data |
| l_rdata | output | 18 | Left read data, zero on lanes that are not valid |
| l_rvld | output | 2 | Left per-lane read valid (bit 0 low lane) |
| r_clk | input | 1 | Right port clock |
| r_ce0_n | input | 1 | Right enable, active low |
| r_ce1 | input | 1 | Right enable, active high |
| r_wr_n | input | 1 | Right read/write: 0 write, 1 read |
| r_lo_n | input | 1 | Right select for bits 8..0, active low |
| r_hi_n | input | 1 | Right select for bits 17..9, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_pipe | input | 1 | Right mode: 0 flow-through, 1 pipelined |
| r_addr | input | 12 | Right word address |
| r_wdata | input | 18 | Right write data |
| r_rdata | output | 18 | Right read data, zero on lanes that are not valid |
| r_rvld | output | 2 | Right per-lane read valid (bit 0 low lane) |

## Verification
Words are written through one port and read through the other at the lowest, highest and a middle address. This separates a correct shared array from per-port copies and from address folding. Reads are placed next to deselected cycles, write cycles, and reads with output enable or a lane select off. The exact cycle in which each result must appear therefore tells flow-through from pipelined latency, and shows any leak of data across lanes or from unselected cycles. Partial-lane writes, and a read of data that arrives with its write strobe held off, show which bits a write may touch. Same-edge cross-port write/read pairs, with both ports in the same mode and in different modes, separate old-data collision behaviour from write-through.

// File: rtl/twin_port_pkg.sv
package twin_port_pkg;

  localparam int unsigned DEF_ADDR_W = 12;
  localparam int unsigned DEF_LANE_W = 9;
  localparam int unsigned PORT_LANES = 2;
  localparam int unsigned PORT_COUNT = 2;

  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;

endpackage

// File: rtl/tp_port_decode.sv
module tp_port_decode #(
  parameter int unsigned LANES = 2
) (
  input  logic             ce0_n,
  input  logic             ce1,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             oe_n,
  output logic             sel,
  output logic             rd_go,
  output logic [LANES-1:0] wr_lane,
  output logic [LANES-1:0] rd_lane
);

  function automatic logic port_on(input logic en_lo_n, input logic en_hi);
    return (!en_lo_n) && en_hi;
  endfunction

  assign sel   = port_on(ce0_n, ce1);
  assign rd_go = sel && wr_n;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wr_lane[i] = sel && !wr_n && !lane_n[i];
    assign rd_lane[i] = rd_go && !oe_n && !lane_n[i];
  end

endmodule

// File: rtl/tp_xor_bank.sv
module tp_xor_bank #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANE_W*LANES-1:0]   wdata,
  input  logic [LANE_W*LANES-1:0]   peer_word,
  input  logic [ADDR_W-1:0]         far_addr,
  output logic [LANE_W*LANES-1:0]   own_word,
  output logic [LANE_W*LANES-1:0]   far_word
);

  localparam int unsigned W     = LANE_W * LANES;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  function automatic logic [LANE_W-1:0] hide(input logic [LANE_W-1:0] d,
                                             input logic [LANE_W-1:0] peer);
    return d ^ peer;
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (we[i]) begin
        mem[addr][i*LANE_W +: LANE_W] <= hide(wdata[i*LANE_W +: LANE_W],
                                              peer_word[i*LANE_W +: LANE_W]);
      end
    end
  end

  assign own_word = mem[addr];
  assign far_word = mem[far_addr];

endmodule

// File: rtl/tp_read_path.sv
module tp_read_path
  import twin_port_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  out_mode_e               mode,
  input  logic [LANES-1:0]        rd_lane,
  input  logic [LANE_W*LANES-1:0] word,
  output logic [LANE_W*LANES-1:0] rdata,
  output logic [LANES-1:0]        rvld
);

  localparam int unsigned W = LANE_W * LANES;

  logic [LANES-1:0] s1_vld, s2_vld, out_vld;
  logic [W-1:0]     s1_dat, s2_dat, out_dat;

  function automatic logic [W-1:0] lane_fill(input logic [LANES-1:0] v);
    logic [W-1:0] m;
    for (int i = 0; i < LANES; i++) begin
      m[i*LANE_W +: LANE_W] = {LANE_W{v[i]}};
    end
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= '0;
      s1_dat <= '0;
      s2_vld <= '0;
      s2_dat <= '0;
    end else begin
      s1_vld <= rd_lane;
      if (|rd_lane) begin
        s1_dat <= word;
      end
      s2_vld <= s1_vld;
      s2_dat <= s1_dat;
    end
  end

  always_comb begin
    if (mode == OUT_PIPE) begin
      out_vld = s2_vld;
      out_dat = s2_dat;
    end else begin
      out_vld = s1_vld;
      out_dat = s1_dat;
    end
  end

  assign rvld  = out_vld;
  assign rdata = out_dat & lane_fill(out_vld);

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import twin_port_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                  rst_n,
  input  logic                  l_clk,
  input  logic                  l_ce0_n,
  input  logic                  l_ce1,
  input  logic                  l_wr_n,
  input  logic                  l_lo_n,
  input  logic                  l_hi_n,
  input  logic                  l_oe_n,
  input  logic                  l_pipe,
  input  logic [ADDR_W-1:0]     l_addr,
  input  logic [2*LANE_W-1:0]   l_wdata,
  output logic [2*LANE_W-1:0]   l_rdata,
  output logic [1:0]            l_rvld,
  input  logic                  r_clk,
  input  logic                  r_ce0_n,
  input  logic                  r_ce1,
  input  logic                  r_wr_n,
  input  logic                  r_lo_n,
  input  logic                  r_hi_n,
  input  logic                  r_oe_n,
  input  logic                  r_pipe,
  input  logic [ADDR_W-1:0]     r_addr,
  input  logic [2*LANE_W-1:0]   r_wdata,
  output logic [2*LANE_W-1:0]   r_rdata,
  output logic [1:0]            r_rvld
);

  localparam int unsigned LANES = PORT_LANES;
  localparam int unsigned NP    = PORT_COUNT;
  localparam int unsigned W     = LANE_W * LANES;

  // Per-port views, index 0 = left, 1 = right.
  logic               clk     [NP];
  logic               ce0_n   [NP];
  logic               ce1     [NP];
  logic               wr_n    [NP];
  logic               oe_n    [NP];
  logic [LANES-1:0]   lane_n  [NP];
  out_mode_e          mode    [NP];
  logic [ADDR_W-1:0]  addr    [NP];
  logic [W-1:0]       wdata   [NP];
  logic [LANES-1:0]   wr_lane [NP];
  logic [LANES-1:0]   rd_lane [NP];
  logic [W-1:0]       own_word[NP];
  logic [W-1:0]       far_word[NP];
  logic [W-1:0]       rd_word [NP];
  logic [W-1:0]       rdata   [NP];
  logic [LANES-1:0]   rvld    [NP];

  // Named internal events for the checker.
  logic [NP-1:0]      sel_v;
  logic [NP-1:0]      rd_go_v;

  function automatic logic [W-1:0] merge_banks(input logic [W-1:0] mine,
                                               input logic [W-1:0] theirs);
    return mine ^ theirs;
  endfunction

  assign clk[0]    = l_clk;
  assign ce0_n[0]  = l_ce0_n;
  assign ce1[0]    = l_ce1;
  assign wr_n[0]   = l_wr_n;
  assign oe_n[0]   = l_oe_n;
  assign lane_n[0] = {l_hi_n, l_lo_n};
  assign mode[0]   = out_mode_e'(l_pipe);
  assign addr[0]   = l_addr;
  assign wdata[0]  = l_wdata;

  assign clk[1]    = r_clk;
  assign ce0_n[1]  = r_ce0_n;
  assign ce1[1]    = r_ce1;
  assign wr_n[1]   = r_wr_n;
  assign oe_n[1]   = r_oe_n;
  assign lane_n[1] = {r_hi_n, r_lo_n};
  assign mode[1]   = out_mode_e'(r_pipe);
  assign addr[1]   = r_addr;
  assign wdata[1]  = r_wdata;

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int unsigned Q = NP - 1 - p;

    tp_port_decode #(.LANES(LANES)) u_dec (
      .ce0_n   (ce0_n[p]),
      .ce1     (ce1[p]),
      .wr_n    (wr_n[p]),
      .lane_n  (lane_n[p]),
      .oe_n    (oe_n[p]),
      .sel     (sel_v[p]),
      .rd_go   (rd_go_v[p]),
      .wr_lane (wr_lane[p]),
      .rd_lane (rd_lane[p])
    );

    tp_xor_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_bank (
      .clk       (clk[p]),
      .we        (wr_lane[p]),
      .addr      (addr[p]),
      .wdata     (wdata[p]),
      .peer_word (far_word[Q]),
      .far_addr  (addr[Q]),
      .own_word  (own_word[p]),
      .far_word  (far_word[p])
    );

    assign rd_word[p] = merge_banks(own_word[p], far_word[Q]);

    tp_read_path #(.LANE_W(LANE_W), .LANES(LANES)) u_out (
      .clk     (clk[p]),
      .rst_n   (rst_n),
      .mode    (mode[p]),
      .rd_lane (rd_lane[p]),
      .word    (rd_word[p]),
      .rdata   (rdata[p]),
      .rvld    (rvld[p])
    );
  end

  assign l_rdata = rdata[0];
  assign l_rvld  = rvld[0];
  assign r_rdata = rdata[1];
  assign r_rvld  = rvld[1];

endmodule

// File: rtl/twin_port_ram_chk.sv
module twin_port_ram_chk (
  input logic       clk_l,
  input logic       clk_r,
  input logic       rst_n,
  input logic [1:0] sel,
  input logic [1:0] rd_go,
  input logic       pipe_l,
  input logic       pipe_r,
  input logic       oe_n_l,
  input logic       oe_n_r,
  input logic       wr_n_l,
  input logic       wr_n_r,
  input logic       lo_n_l,
  input logic       hi_n_l,
  input logic       lo_n_r,
  input logic       hi_n_r,
  input logic [1:0] vld_l,
  input logic [1:0] vld_r
);

  // R2: an unselected edge yields nothing in flow-through mode
  a_r2_quiet_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    !sel[0] |=> (pipe_l || vld_l == 2'b00));
  a_r2_quiet_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    !sel[1] |=> (pipe_r || vld_r == 2'b00));

  // R3: flow-through data only from a read edge
  a_r3_read_only_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    (!pipe_l && vld_l != 2'b00) |-> $past(wr_n_l));
  a_r3_read_only_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    (!pipe_r && vld_r != 2'b00) |-> $past(wr_n_r));

  // R5: lane gating by output enable and lane select
  a_r5_lo_gate_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    (!pipe_l && vld_l[0]) |-> $past(!oe_n_l && !lo_n_l));
  a_r5_hi_gate_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    (!pipe_l && vld_l[1]) |-> $past(!oe_n_l && !hi_n_l));
  a_r5_lo_gate_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    (!pipe_r && vld_r[0]) |-> $past(!oe_n_r && !lo_n_r));
  a_r5_hi_gate_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    (!pipe_r && vld_r[1]) |-> $past(!oe_n_r && !hi_n_r));

  // R6: flow-through valid data follows a read one edge earlier
  a_r6_flow_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    (!pipe_l && vld_l != 2'b00) |-> $past(rd_go[0]));
  a_r6_flow_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    (!pipe_r && vld_r != 2'b00) |-> $past(rd_go[1]));

  // R7: pipelined valid data follows a read two edges earlier
  a_r7_pipe_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    (pipe_l && vld_l != 2'b00) |-> $past(rd_go[0], 2));
  a_r7_pipe_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    (pipe_r && vld_r != 2'b00) |-> $past(rd_go[1], 2));

  // R8: pipelined outputs stay off for the cycle after a deselect
  a_r8_reactivate_l: assert property (@(posedge clk_l) disable iff (!rst_n)
    (pipe_l && $past(!sel[0], 2)) |-> vld_l == 2'b00);
  a_r8_reactivate_r: assert property (@(posedge clk_r) disable iff (!rst_n)
    (pipe_r && $past(!sel[1], 2)) |-> vld_r == 2'b00);

endmodule

bind twin_port_ram twin_port_ram_chk i_chk (
  .clk_l  (l_clk),
  .clk_r  (r_clk),
  .rst_n  (rst_n),
  .sel    (sel_v),
  .rd_go  (rd_go_v),
  .pipe_l (l_pipe),
  .pipe_r (r_pipe),
  .oe_n_l (l_oe_n),
  .oe_n_r (r_oe_n),
  .wr_n_l (l_wr_n),
  .wr_n_r (r_wr_n),
  .lo_n_l (l_lo_n),
  .hi_n_l (l_hi_n),
  .lo_n_r (r_lo_n),
  .hi_n_r (r_hi_n),
  .vld_l  (l_rvld),
  .vld_r  (r_rvld)
);

// File: tb/test_twin_port_ram.sv
module test_twin_port_ram;

  localparam int AW = 12;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic l_ce0_n, l_ce1, l_wr_n, l_lo_n, l_hi_n, l_oe_n, l_pipe;
  logic r_ce0_n, r_ce1, r_wr_n, r_lo_n, r_hi_n, r_oe_n, r_pipe;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata;
  logic [DW-1:0] l_rdata, r_rdata;
  logic [1:0]    l_rvld, r_rvld;

  twin_port_ram i_twin_port_ram (
    .rst_n(rst_n),
    .l_clk(clk), .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_wr_n(l_wr_n),
    .l_lo_n(l_lo_n), .l_hi_n(l_hi_n), .l_oe_n(l_oe_n), .l_pipe(l_pipe),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvld(l_rvld),
    .r_clk(clk), .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_wr_n(r_wr_n),
    .r_lo_n(r_lo_n), .r_hi_n(r_hi_n), .r_oe_n(r_oe_n), .r_pipe(r_pipe),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvld(r_rvld)
  );

  typedef struct {
    logic          ce0_n, ce1, wr_n, lo_n, hi_n, oe_n;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    bit            chk;
    string         tag;
  } op_t;

  typedef struct {
    int            due;
    logic [DW-1:0] d;
    logic [1:0]    v;
    string         tag;
  } exp_t;

  exp_t q_l[$];
  exp_t q_r[$];
  logic [DW-1:0] shadow [int];
  int edge_n  = 0;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [AW-1:0] A_LO  = 12'h000;
  localparam logic [AW-1:0] A_HI  = 12'hFFF;
  localparam logic [AW-1:0] A_MID = 12'h5A3;

  function automatic op_t mk(logic ce0_n, logic ce1, logic wr_n, logic lo_n, logic hi_n,
                             logic oe_n, logic [AW-1:0] a, logic [DW-1:0] d, bit chk, string tag);
    op_t o;
    o.ce0_n = ce0_n; o.ce1 = ce1; o.wr_n = wr_n; o.lo_n = lo_n; o.hi_n = hi_n;
    o.oe_n = oe_n; o.a = a; o.d = d; o.chk = chk; o.tag = tag;
    return o;
  endfunction

  function automatic op_t rd(logic [AW-1:0] a, string tag);
    return mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, a, '0, 1'b1, tag);
  endfunction
  function automatic op_t wr(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    return mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, a, d, 1'b1, tag);
  endfunction
  function automatic op_t nop(string tag);
    return mk(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0, 1'b1, tag);
  endfunction
  function automatic op_t skip();
    return mk(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0, 1'b0, "none");
  endfunction

  // Bits kept by the valid lanes: low lane 0x001FF, high lane 0x3FE00.
  function automatic logic [DW-1:0] keep(logic [1:0] v);
    logic [DW-1:0] k = '0;
    if (v[0]) k = k | 18'h001FF;
    if (v[1]) k = k | 18'h3FE00;
    return k;
  endfunction

  function automatic exp_t predict(op_t o, logic pipe);
    exp_t e;
    logic taken, reading;
    taken   = !o.ce0_n && o.ce1;
    reading = taken && o.wr_n;
    e.due   = edge_n + 1 + (pipe ? 1 : 0);
    e.v[0]  = reading && !o.oe_n && !o.lo_n;
    e.v[1]  = reading && !o.oe_n && !o.hi_n;
    e.d     = (e.v != 2'b00) ? (shadow[int'(o.a)] & keep(e.v)) : '0;
    e.tag   = o.tag;
    return e;
  endfunction

  task automatic store(op_t o);
    logic [DW-1:0] w;
    if (!o.ce0_n && o.ce1 && !o.wr_n) begin
      w = shadow.exists(int'(o.a)) ? shadow[int'(o.a)] : '0;
      if (!o.lo_n) w = (w & 18'h3FE00) | (o.d & 18'h001FF);
      if (!o.hi_n) w = (w & 18'h001FF) | (o.d & 18'h3FE00);
      shadow[int'(o.a)] = w;
    end
  endtask

  task automatic drive(op_t l, op_t r);
    l_ce0_n = l.ce0_n; l_ce1 = l.ce1; l_wr_n = l.wr_n; l_lo_n = l.lo_n;
    l_hi_n = l.hi_n; l_oe_n = l.oe_n; l_addr = l.a; l_wdata = l.d;
    r_ce0_n = r.ce0_n; r_ce1 = r.ce1; r_wr_n = r.wr_n; r_lo_n = r.lo_n;
    r_hi_n = r.hi_n; r_oe_n = r.oe_n; r_addr = r.a; r_wdata = r.d;
  endtask

  // Driver: one operation per port per clock; reads predicted before writes apply.
  task automatic cyc(op_t l, op_t r);
    exp_t el, er;
    @(negedge clk);
    drive(l, r);
    el = predict(l, l_pipe);
    er = predict(r, r_pipe);
    if (l.chk) q_l.push_back(el);
    if (r.chk) q_r.push_back(er);
    store(l);
    store(r);
  endtask

  task automatic drain();
    repeat (3) cyc(skip(), skip());
  endtask

  task automatic set_mode(logic lm, logic rm);
    drain();
    @(negedge clk);
    l_pipe = lm;
    r_pipe = rm;
  endtask

  task automatic compare(string side, exp_t e, logic [DW-1:0] d, logic [1:0] v);
    n_tests++;
    if (d !== e.d || v !== e.v) begin
      n_fail++;
      $display("FAIL %s %s port at edge %0d: rdata=%h rvld=%b expected rdata=%h rvld=%b",
               e.tag, side, edge_n, d, v, e.d, e.v);
    end
  endtask

  always @(posedge clk) edge_n = edge_n + 1;

  // Monitor: sample a quarter period after each edge, pop what is due.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q_l.size() > 0 && q_l[0].due <= edge_n) begin
        exp_t e;
        e = q_l.pop_front();
        compare("left", e, l_rdata, l_rvld);
      end
      while (q_r.size() > 0 && q_r[0].due <= edge_n) begin
        exp_t e;
        e = q_r.pop_front();
        compare("right", e, r_rdata, r_rvld);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: edges=%0d expected completion before 20000", edge_n);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    op_t o;
    drive(skip(), skip());
    l_pipe = 1'b0;
    r_pipe = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);

    // R10: outputs held at zero during reset
    n_tests++;
    if (l_rvld !== 2'b00 || l_rdata !== '0) begin
      n_fail++;
      $display("FAIL R10 left in reset: rdata=%h rvld=%b expected rdata=0 rvld=00", l_rdata, l_rvld);
    end
    n_tests++;
    if (r_rvld !== 2'b00 || r_rdata !== '0) begin
      n_fail++;
      $display("FAIL R10 right in reset: rdata=%h rvld=%b expected rdata=0 rvld=00", r_rdata, r_rvld);
    end
    rst_n = 1'b1;
    drain();

    // R1: cross-port write/read at both address ends and the middle
    cyc(wr(A_MID, 18'h2A5A5, "R1"), wr(A_HI, 18'h3FFFF, "R1"));
    cyc(rd(A_HI, "R1"), rd(A_MID, "R1"));
    cyc(wr(A_LO, 18'h15A5A, "R1"), nop("R2"));
    // R6: flow-through, with quiet cycles around the read
    cyc(nop("R6"), rd(A_LO, "R6"));
    cyc(rd(A_LO, "R6"), nop("R6"));
    cyc(nop("R6"), nop("R6"));

    // R2: deselect variants neither write nor read
    o = wr(A_MID, 18'h00000, "R2"); o.ce0_n = 1'b1;
    cyc(o, skip());
    o = wr(A_MID, 18'h00000, "R2"); o.ce1 = 1'b0;
    cyc(o, skip());
    o = rd(A_MID, "R2"); o.ce1 = 1'b0;
    cyc(rd(A_MID, "R2"), o);
    o = rd(A_MID, "R2"); o.ce0_n = 1'b1; o.ce1 = 1'b0;
    cyc(nop("R2"), o);

    // R3: a read edge with data on the write bus leaves memory alone
    o = rd(A_MID, "R3"); o.d = 18'h11111;
    cyc(o, skip());
    cyc(rd(A_MID, "R3"), skip());

    // R4: lane-limited writes
    o = wr(A_MID, 18'h0C3C3, "R4"); o.hi_n = 1'b1;
    cyc(o, skip());
    cyc(rd(A_MID, "R4"), skip());
    o = wr(A_HI, 18'h00000, "R4"); o.lo_n = 1'b1;
    cyc(skip(), o);
    cyc(skip(), rd(A_HI, "R4"));

    // R5: output enable and lane-select gating on reads
    o = rd(A_MID, "R5"); o.oe_n = 1'b1;
    cyc(o, skip());
    o = rd(A_MID, "R5"); o.hi_n = 1'b1;
    cyc(o, skip());
    o = rd(A_HI, "R5"); o.lo_n = 1'b1;
    cyc(skip(), o);

    // R9: same-edge cross-port write and read, both directions
    cyc(wr(A_MID, 18'h3C00F, "R9"), rd(A_MID, "R9"));
    cyc(skip(), rd(A_MID, "R9"));
    cyc(rd(A_LO, "R9"), wr(A_LO, 18'h00777, "R9"));
    cyc(rd(A_LO, "R9"), skip());

    // R7: pipelined latency and streaming
    set_mode(1'b1, 1'b1);
    cyc(rd(A_MID, "R7"), rd(A_LO, "R7"));
    cyc(rd(A_HI, "R7"), rd(A_MID, "R7"));
    cyc(nop("R7"), nop("R7"));
    cyc(wr(A_HI, 18'h2468A, "R7"), skip());
    cyc(rd(A_HI, "R7"), skip());
    cyc(nop("R7"), skip());

    // R8: pipelined reactivation after a deselect
    cyc(rd(A_MID, "R8"), skip());
    cyc(nop("R8"), skip());
    cyc(rd(A_HI, "R8"), skip());
    o = rd(A_LO, "R8"); o.ce1 = 1'b0;
    cyc(o, skip());
    cyc(rd(A_LO, "R8"), skip());
    cyc(nop("R8"), skip());

    // R6/R7: ports in different modes at once, plus a collision (R9)
    set_mode(1'b0, 1'b1);
    cyc(rd(A_MID, "R6"), rd(A_MID, "R7"));
    cyc(wr(A_HI, 18'h13579, "R9"), rd(A_HI, "R9"));
    cyc(nop("R6"), rd(A_HI, "R9"));
    cyc(nop("R6"), nop("R8"));
    set_mode(1'b0, 1'b0);
    drain();

    // R10: reset clears a live flow-through output at once
    @(negedge clk);
    drive(rd(A_MID, "R10"), skip());
    @(posedge clk);
    #5;
    n_tests++;
    if (l_rvld !== 2'b11 || l_rdata !== shadow[int'(A_MID)]) begin
      n_fail++;
      $display("FAIL R6 left before reset: rdata=%h rvld=%b expected rdata=%h rvld=11",
               l_rdata, l_rvld, shadow[int'(A_MID)]);
    end
    @(negedge clk);
    drive(skip(), skip());
    rst_n = 1'b0;
    #1;
    n_tests++;
    if (l_rvld !== 2'b00 || l_rdata !== '0) begin
      n_fail++;
      $display("FAIL R10 left after reset: rdata=%h rvld=%b expected rdata=0 rvld=00", l_rdata, l_rvld);
    end

    if (q_l.size() != 0 || q_r.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1 scoreboard: left=%0d right=%0d items left expected 0",
               q_l.size(), q_r.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule